// File: doc/BRIEF.md
# Preamble and Start-of-Frame Detector

This block sits behind a clock and data recovery stage and watches the recovered, still line-coded bit stream. Each bit arrives with a one-cycle valid strobe. The block first looks for a valid preamble. The form of that preamble depends on the selected modulation class and line coding. Once the preamble is valid, the block searches for the start-of-frame byte that belongs to the same mode. When the byte is found, it emits a single-cycle frame-start pulse. Frequency-modulated NRZ traffic has no start-of-frame byte, so in that mode the pulse follows directly from the strobe that completes the preamble.

Two inputs set the mode: `mod_fm` (0 selects amplitude modulation, 1 selects frequency modulation) and `code_manch` (0 selects NRZ, 1 selects Manchester). Bits enter a shift register most significant bit first. After a frame start, the block stops taking bits until it is re-armed. The input is a valid/ready stream: a bit is consumed only on a cycle where `bit_valid` and `bit_ready` are both high. `bit_ready` is low from the frame start until `rearm`. While `bit_ready` is low the producer may keep `bit_valid` asserted, and those bits are discarded and have no effect. Outside that state `bit_ready` stays high, so the block never stalls a stream it is hunting in.

Top module: `frame_sync_det`

## Requirements
- R1: After reset, `frame_start`, `preamble_ok` and `sof_timeout` are 0 and `bit_ready` is 1.
- R2: With amplitude modulation (either coding), the preamble is PRE_MIN (default 8) consecutive accepted 1 bits. An accepted 0 restarts the count from zero.
- R3: With frequency modulation and NRZ, the preamble is PRE_MIN consecutive accepted bits that alternate. A bit equal to its predecessor restarts the count, and that bit counts as the first of a new run. The strobe that completes the count yields `frame_start` without any byte search, and `preamble_ok` never rises.
- R4: With frequency modulation and Manchester, the preamble is PRE_MIN consecutive equal bits of either polarity. A change of value restarts the count at one.
- R5: With amplitude modulation and NRZ, the start-of-frame byte is 0x55.
- R6: With amplitude modulation and Manchester, the start-of-frame byte is 0x0A.
- R7: With frequency modulation and Manchester, both 0x55 and 0xAA are accepted as start-of-frame bytes.
- R8: `preamble_ok` is 1 from the clock after the strobe that completes the preamble until a frame start, a timeout or a rearm.
- R9: If SOF_WINDOW (default 32) strobes are accepted after the preamble without a byte match, `sof_timeout` is set on the SOF_WINDOW-th strobe. `preamble_ok` drops and the preamble hunt restarts from a zero count. `sof_timeout` stays set until `rearm`.
- R10: `frame_start` is 1 for exactly one clock, in the clock after the strobe that carries the last byte bit (bits sent MSB first, the last bit being bit 0). After it, `bit_ready` is 0 and strobes have no effect until `rearm`.
- R11: `rearm` returns the block to the preamble hunt with all counts cleared, clears `sof_timeout`, and sets `bit_ready` to 1 on the next clock.
- R12: `bit_data` has no effect on any cycle where `bit_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_fm | input | 1 | 1: frequency modulation, 0: amplitude modulation |
| code_manch | input | 1 | 1: Manchester line coding, 0: NRZ |
| rearm | input | 1 | Restart the hunt and clear the timeout flag |
| bit_valid | input | 1 | Recovered bit strobe (stream valid) |
| bit_data | input | 1 | Recovered bit value |
| bit_ready | output | 1 | Block accepts bits (low after frame start) |
| preamble_ok | output | 1 | Preamble seen, start-of-frame search active |
| frame_start | output | 1 | One-clock frame boundary pulse |
| sof_timeout | output | 1 | Sticky flag: no start-of-frame within the window |

## Verification
On every cycle, the assertions check that the frame-start pulse is one clock wide, that it comes only after an accepted strobe, and that it coincides with back-pressure. They also check that a timeout always drops the search flag, that rearm restores readiness, and that the run and window counters stay within their limits. Only the directed scenarios can show which bit pattern counts as a preamble in each mode and which bytes end the search. The scenarios also cover the exact strobe on which the pulse or the timeout appears, and the fact that bits offered during back-pressure or idle cycles change nothing.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_DONE   = 2'd2
  } fsd_state_e;

  typedef struct packed {
    logic fm;
    logic manch;
  } fsd_mode_t;

  function automatic logic mode_needs_sof(fsd_mode_t m);
    return !(m.fm && !m.manch);
  endfunction

endpackage

// File: rtl/fsd_pre_counter.sv
module fsd_pre_counter
  import fsd_pkg::*;
#(
  parameter int PRE_MIN = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      step,
  input  logic      bit_in,
  input  fsd_mode_t mode,
  output logic      hit
);
  localparam int CW = $clog2(PRE_MIN + 1);
  localparam logic [CW-1:0] MIN_C = CW'(PRE_MIN);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, inc;
  logic          prev_q;

  always_comb begin
    inc = (cnt_q == MIN_C) ? MIN_C : cnt_q + ONE_C;
    if (cnt_q == '0) begin
      cnt_d = (!mode.fm && !bit_in) ? '0 : ONE_C;
    end else if (!mode.fm) begin
      cnt_d = bit_in ? inc : '0;
    end else if (mode.manch) begin
      cnt_d = (bit_in == prev_q) ? inc : ONE_C;
    end else begin
      cnt_d = (bit_in != prev_q) ? inc : ONE_C;
    end
  end

  assign hit = step && (cnt_d == MIN_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else if (step) begin
      cnt_q  <= cnt_d;
      prev_q <= bit_in;
    end
  end

  // R2
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MIN_C);

  // R11
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/fsd_sof_match.sv
module fsd_sof_match
  import fsd_pkg::*;
#(
  parameter int          SOF_W       = 8,
  parameter logic [7:0]  SOF_AM_NRZ  = 8'h55,
  parameter logic [7:0]  SOF_AM_MAN  = 8'h0A,
  parameter logic [7:0]  SOF_FM_MAN0 = 8'h55,
  parameter logic [7:0]  SOF_FM_MAN1 = 8'hAA
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      shift,
  input  logic      bit_in,
  input  fsd_mode_t mode,
  output logic      hit
);
  logic [SOF_W-1:0] sh_q;
  logic [SOF_W-1:0] win;
  logic             any_match;

  assign win = {sh_q[SOF_W-2:0], bit_in};

  always_comb begin
    unique case ({mode.fm, mode.manch})
      2'b00:   any_match = (win == SOF_AM_NRZ[SOF_W-1:0]);
      2'b01:   any_match = (win == SOF_AM_MAN[SOF_W-1:0]);
      2'b11:   any_match = (win == SOF_FM_MAN0[SOF_W-1:0]) ||
                           (win == SOF_FM_MAN1[SOF_W-1:0]);
      default: any_match = 1'b0;
    endcase
  end

  assign hit = shift && any_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh_q <= '0;
    else if (clear)  sh_q <= '0;
    else if (shift)  sh_q <= win;
  end

  // R10
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clear) |=> $stable(sh_q));

endmodule

// File: rtl/fsd_window_timer.sv
module fsd_window_timer #(
  parameter int SOF_WINDOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic expire
);
  localparam int WW = $clog2(SOF_WINDOW + 1);
  localparam logic [WW-1:0] LAST_C = WW'(SOF_WINDOW - 1);

  logic [WW-1:0] cnt_q;

  assign expire = step && (cnt_q == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (step)   cnt_q <= expire ? '0 : cnt_q + WW'(1);
  end

  // R9
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);

endmodule

// File: rtl/frame_sync_det.sv
module frame_sync_det
  import fsd_pkg::*;
#(
  parameter int PRE_MIN    = 8,
  parameter int SOF_WINDOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_fm,
  input  logic code_manch,
  input  logic rearm,
  input  logic bit_valid,
  input  logic bit_data,
  output logic bit_ready,
  output logic preamble_ok,
  output logic frame_start,
  output logic sof_timeout
);
  fsd_state_e state_q;
  fsd_mode_t  mode;
  logic       accept, hunt_step, search_step;
  logic       pre_hit, sof_hit, win_expire;
  logic       fs_q, to_q;

  assign mode        = '{fm: mod_fm, manch: code_manch};
  assign bit_ready   = (state_q != ST_DONE);
  assign accept      = bit_valid && bit_ready && !rearm;
  assign hunt_step   = accept && (state_q == ST_HUNT);
  assign search_step = accept && (state_q == ST_SEARCH);

  fsd_pre_counter #(.PRE_MIN(PRE_MIN)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (rearm || (state_q != ST_HUNT)),
    .step   (hunt_step),
    .bit_in (bit_data),
    .mode   (mode),
    .hit    (pre_hit)
  );

  fsd_sof_match u_sof (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (rearm),
    .shift  (accept),
    .bit_in (bit_data),
    .mode   (mode),
    .hit    (sof_hit)
  );

  fsd_window_timer #(.SOF_WINDOW(SOF_WINDOW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (rearm || (state_q != ST_SEARCH)),
    .step   (search_step),
    .expire (win_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      fs_q    <= 1'b0;
      to_q    <= 1'b0;
    end else if (rearm) begin
      state_q <= ST_HUNT;
      fs_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      fs_q <= 1'b0;
      unique case (state_q)
        ST_HUNT: if (pre_hit) begin
          if (mode_needs_sof(mode)) begin
            state_q <= ST_SEARCH;
          end else begin
            state_q <= ST_DONE;
            fs_q    <= 1'b1;
          end
        end
        ST_SEARCH: if (search_step && sof_hit) begin
          state_q <= ST_DONE;
          fs_q    <= 1'b1;
        end else if (win_expire) begin
          state_q <= ST_HUNT;
          to_q    <= 1'b1;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign preamble_ok = (state_q == ST_SEARCH);
  assign frame_start = fs_q;
  assign sof_timeout = to_q;

  // R10
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R10
  fs_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(bit_valid && bit_ready));

  // R10
  fs_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !bit_ready);

  // R9
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_timeout) |-> (!preamble_ok && $past(preamble_ok)));

  // R11
  rearm_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> (bit_ready && !sof_timeout && !frame_start));

  // R8
  pok_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(preamble_ok && frame_start));

endmodule

// File: tb/sim_frame_sync_det.sv
`timescale 1ns/1ps
module sim_frame_sync_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mod_fm = 1'b0, code_manch = 1'b0, rearm = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, preamble_ok, frame_start, sof_timeout;
  int   n_checks = 0;
  int   n_err = 0;

  always #10 clk = ~clk;

  frame_sync_det u0 (
    .clk(clk), .rst_n(rst_n), .mod_fm(mod_fm), .code_manch(code_manch),
    .rearm(rearm), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .preamble_ok(preamble_ok),
    .frame_start(frame_start), .sof_timeout(sof_timeout)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one strobe, then an idle cycle carrying the inverted value (R12)
  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_data = b;
    @(negedge clk); bit_valid = 1'b0; bit_data = ~b;
  endtask

  task automatic send_run(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic send_sof(input logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) begin
      send_bit(v[i]);
      chk(tag, frame_start, (i == 0));
    end
  endtask

  task automatic do_rearm(input logic fm, input logic man);
    @(negedge clk); mod_fm = fm; code_manch = man; rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
    chk("R11 ready after rearm", bit_ready, 1'b1);
    chk("R11 timeout cleared", sof_timeout, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 frame_start", frame_start, 1'b0);
    chk("R1 preamble_ok", preamble_ok, 1'b0);
    chk("R1 sof_timeout", sof_timeout, 1'b0);
    chk("R1 bit_ready", bit_ready, 1'b1);
  endtask

  task automatic t_am_nrz;
    do_rearm(1'b0, 1'b0);
    send_run(1'b1, 5); send_bit(1'b0); send_run(1'b1, 7);
    chk("R2 zero restarts run", preamble_ok, 1'b0);
    send_bit(1'b1);
    chk("R8 preamble_ok raised", preamble_ok, 1'b1);
    send_sof(8'h55, "R5 am nrz sof");
    chk("R10 back-pressure", bit_ready, 1'b0);
    chk("R8 pok low after frame", preamble_ok, 1'b0);
    @(negedge clk);
    chk("R10 pulse one clock", frame_start, 1'b0);
    send_run(1'b1, 8);
    for (int i = 7; i >= 0; i--) begin
      send_bit(i[0] ? 1'b0 : 1'b1);
      chk("R10 strobes ignored while done", frame_start, 1'b0);
    end
    chk("R10 still not ready", bit_ready, 1'b0);
  endtask

  task automatic t_am_man;
    do_rearm(1'b0, 1'b1);
    send_run(1'b1, 8);
    chk("R2 am manch preamble", preamble_ok, 1'b1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    chk("R6 0x55 not accepted half", frame_start, 1'b0);
    do_rearm(1'b0, 1'b1);
    send_run(1'b1, 8);
    send_sof(8'h0A, "R6 am manch sof");
  endtask

  task automatic t_fm_nrz;
    do_rearm(1'b1, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    for (int i = 0; i < 6; i++) begin
      send_bit(i[0] ? 1'b1 : 1'b0);
      chk("R3 no early frame", frame_start, 1'b0);
      chk("R3 pok stays low", preamble_ok, 1'b0);
    end
    send_bit(1'b0);
    chk("R3 frame on preamble end", frame_start, 1'b1);
    chk("R3 pok never high", preamble_ok, 1'b0);
  endtask

  task automatic t_fm_man;
    do_rearm(1'b1, 1'b1);
    send_run(1'b1, 4); send_run(1'b0, 7);
    chk("R4 polarity change restarts", preamble_ok, 1'b0);
    send_bit(1'b0);
    chk("R4 zero run preamble", preamble_ok, 1'b1);
    send_sof(8'h55, "R7 fm manch 0x55");
    do_rearm(1'b1, 1'b1);
    send_run(1'b1, 8);
    chk("R4 one run preamble", preamble_ok, 1'b1);
    send_sof(8'hAA, "R7 fm manch 0xAA");
  endtask

  task automatic t_timeout;
    do_rearm(1'b0, 1'b0);
    send_run(1'b1, 8);
    chk("R8 pok before window", preamble_ok, 1'b1);
    send_run(1'b1, 31);
    chk("R9 no timeout at 31", sof_timeout, 1'b0);
    chk("R9 pok held at 31", preamble_ok, 1'b1);
    send_bit(1'b1);
    chk("R9 timeout at 32", sof_timeout, 1'b1);
    chk("R9 pok dropped", preamble_ok, 1'b0);
    send_run(1'b1, 7);
    chk("R9 hunt restarted from zero", preamble_ok, 1'b0);
    send_bit(1'b1);
    chk("R9 hunt finds preamble again", preamble_ok, 1'b1);
    chk("R9 timeout sticky", sof_timeout, 1'b1);
    do_rearm(1'b0, 1'b0);
    chk("R11 rearm leaves search", preamble_ok, 1'b0);
  endtask

  task automatic t_idle;
    do_rearm(1'b0, 1'b0);
    send_run(1'b1, 7);
    @(negedge clk); bit_data = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 idle data ignored", preamble_ok, 1'b0);
    send_bit(1'b1);
    chk("R12 run survives idle zeros", preamble_ok, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_am_nrz();
    t_am_man();
    t_fm_nrz();
    t_fm_man();
    t_timeout();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule